// File: doc/BRIEF.md
# Burst Output-Acquire Sequencer

This block plays a stored list of output codes to a single DAC channel at a fixed step rate. After each output update it takes one sample from input channel 1 and one from input channel 2 through an ADC handshake. Both results go into a capture memory, at an address equal to the step's offset from the start of the list. The host fills the code table through a write port. It then sets a start index, an end index, an extra-delay count, a cycle count and a repeat count, and pulses `run`. The list from start to end is played cycles×repeat times. `busy` stays high for the whole run.

After the run the host reads the captured pairs back one address at a time through the read port. The table is never changed by a run, so `run` can be pulsed again with no reload. Settings the block cannot execute are rejected with an error flag, and no run starts.

The DAC and the ADC are modelled as request/acknowledge handshakes. A request stays high until its acknowledge is seen on a clock edge.

Top module: `burst_seq_top`

## Requirements
- R1: While the block is idle, a `tbl_we` pulse stores `tbl_wdata` at index `tbl_waddr`. During a run, `dac_code` presents table entries start, start+1, …, end in index order, once per step, and is valid while `dac_req` is high.
- R2: Within a step the DAC handshake completes first. Then one ADC handshake runs with `adc_chan`=0 (input 1), then one with `adc_chan`=1 (input 2). The pair is stored at capture offset (index − start). `dac_req` and `adc_req` are never high together. A request and `adc_chan` hold steady until acknowledged.
- R3: While handshakes finish within the interval, a new step begins every STEP_CYC×(extra-delay+1) clock cycles. `busy` is high for exactly total steps × that interval.
- R4: The list from start to end is played cycles×repeat times in one run.
- R5: While `busy` is high, the block ignores `run`, table writes and read requests. A run pulse does not restart or lengthen the run, a write does not change the table, and a read gives no `rd_valid`.
- R6: A new run pulse after a run replays the table loaded earlier, with no reload.
- R7: Captured data leaves only through the read port, and only while idle. A `rd_en` pulse gives `rd_valid` high one cycle later, with `rd_data1` = input-1 sample and `rd_data2` = input-2 sample of offset `rd_addr`. `rd_valid` is never high while `busy` is.
- R8: With more than one pass, each pass overwrites the capture memory, so readback returns the samples of the last pass.
- R9: A run pulse with cycles=0, repeat=0, end<start, or end>DEPTH−1 (a span above DEPTH entries) sets `cfg_err` and does not raise `busy`. The next accepted run clears `cfg_err`.
- R10: `done` is a one-cycle pulse, high in the first cycle in which `busy` is low again after a run.
- R11: After reset `busy`, `done`, `cfg_err`, `dac_req`, `adc_req` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Code table write strobe |
| tbl_waddr | input | IDX_W | Code table write index |
| tbl_wdata | input | CODE_W | Code to store |
| cfg_start | input | IDX_W | First table index of the list |
| cfg_end | input | IDX_W | Last table index of the list |
| cfg_xdly | input | DLY_W | Extra delay: the step interval is STEP_CYC×(value+1) |
| cfg_cycles | input | CNT_W | Cycle count |
| cfg_repeat | input | CNT_W | Repeat count |
| run | input | 1 | Start pulse |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| cfg_err | output | 1 | Last run pulse carried invalid settings |
| dac_req | output | 1 | DAC update request |
| dac_code | output | CODE_W | Code to convert, valid with dac_req |
| dac_ack | input | 1 | DAC update acknowledge |
| adc_req | output | 1 | ADC sample request |
| adc_chan | output | 1 | 0 selects input 1, 1 selects input 2 |
| adc_ack | input | 1 | ADC acknowledge, adc_data valid |
| adc_data | input | SAMP_W | ADC result |
| rd_en | input | 1 | Capture read request |
| rd_addr | input | IDX_W | Capture offset to read |
| rd_valid | output | 1 | Read data valid |
| rd_data1 | output | SAMP_W | Input-1 sample |
| rd_data2 | output | SAMP_W | Input-2 sample |

## Verification
If the index or pass counters were corrupted, the DAC code sequence would show it at the first wrong step. The `busy` length would also be off by a whole multiple of the step interval when the run ends. A timer fault shows up as irregular gaps between DAC acknowledges, which the bench timestamps within one step. A wrong write offset, a channel swap or a capture from an earlier pass shows up at readback, because every ADC sample carries a value derived from its global sequence number.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DAC,
    ST_ADC1,
    ST_ADC2,
    ST_WAIT
  } seq_state_t;
endpackage

// File: rtl/burst_sdp_ram.sv
module burst_sdp_ram #(
  parameter int DEPTH = 100,
  parameter int AW    = 7,
  parameter int DW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
    if (int'(raddr) < DEPTH) rdata <= mem[raddr];
    else                     rdata <= '0;
  end
endmodule

// File: rtl/burst_step_timer.sv
module burst_step_timer #(
  parameter int STEP_CYC = 25000,
  parameter int DLY_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             enable,
  input  logic [DLY_W-1:0] xdly,
  output logic             expired
);
  localparam int BASE_W = ($clog2(STEP_CYC) < 1) ? 1 : $clog2(STEP_CYC);
  localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(STEP_CYC - 1);

  logic [BASE_W-1:0] base_q;
  logic [DLY_W-1:0]  slot_q;

  assign expired = (base_q == BASE_LAST) && (slot_q == xdly);

  // base counter wraps every STEP_CYC cycles; slot counts the wraps;
  // the pair saturates at the final value until restarted
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      base_q <= '0;
      slot_q <= '0;
    end else if (enable && !expired) begin
      if (base_q == BASE_LAST) begin
        base_q <= '0;
        slot_q <= slot_q + 1'b1;
      end else begin
        base_q <= base_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int DEPTH  = 100,
  parameter int IDX_W  = 7,
  parameter int SAMP_W = 10,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [IDX_W-1:0]  cfg_start,
  input  logic [IDX_W-1:0]  cfg_end,
  input  logic [DLY_W-1:0]  cfg_xdly,
  input  logic [CNT_W-1:0]  cfg_cycles,
  input  logic [CNT_W-1:0]  cfg_repeat,
  input  logic              tmr_expired,
  input  logic              dac_ack,
  input  logic              adc_ack,
  input  logic [SAMP_W-1:0] adc_data,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic              dac_req,
  output logic              adc_req,
  output logic              adc_chan,
  output logic [IDX_W-1:0]  tbl_raddr,
  output logic [DLY_W-1:0]  act_xdly,
  output logic              step_go,
  output logic                acq_we,
  output logic [IDX_W-1:0]    acq_waddr,
  output logic [2*SAMP_W-1:0] acq_wdata
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DEPTH - 1);

  seq_state_t        state_q;
  logic [IDX_W-1:0]  idx_q, st_start_q, st_end_q;
  logic [CNT_W-1:0]  st_cyc_q, st_rep_q, cyc_q, rep_q;
  logic [SAMP_W-1:0] samp1_q;
  logic              cfg_bad, last_step, pass_end, cyc_end;

  assign cfg_bad   = (cfg_cycles == '0) || (cfg_repeat == '0) ||
                     (cfg_end < cfg_start) || (cfg_end > IDX_MAX);
  assign pass_end  = (idx_q == st_end_q);
  assign cyc_end   = (cyc_q == st_cyc_q - 1'b1);
  assign last_step = pass_end && cyc_end && (rep_q == st_rep_q - 1'b1);
  assign step_go   = ((state_q == ST_IDLE) && run && !cfg_bad) ||
                     ((state_q == ST_WAIT) && tmr_expired && !last_step);
  assign tbl_raddr = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      cfg_err    <= 1'b0;
      dac_req    <= 1'b0;
      adc_req    <= 1'b0;
      adc_chan   <= 1'b0;
      acq_we     <= 1'b0;
      acq_waddr  <= '0;
      acq_wdata  <= '0;
      idx_q      <= '0;
      st_start_q <= '0;
      st_end_q   <= '0;
      st_cyc_q   <= '0;
      st_rep_q   <= '0;
      act_xdly   <= '0;
      cyc_q      <= '0;
      rep_q      <= '0;
      samp1_q    <= '0;
    end else begin
      done   <= 1'b0;
      acq_we <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (run) begin
            if (cfg_bad) begin
              cfg_err <= 1'b1;
            end else begin
              cfg_err    <= 1'b0;
              busy       <= 1'b1;
              st_start_q <= cfg_start;
              st_end_q   <= cfg_end;
              st_cyc_q   <= cfg_cycles;
              st_rep_q   <= cfg_repeat;
              act_xdly   <= cfg_xdly;
              idx_q      <= cfg_start;
              cyc_q      <= '0;
              rep_q      <= '0;
              state_q    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          // table read of idx_q lands together with the request
          dac_req <= 1'b1;
          state_q <= ST_DAC;
        end
        ST_DAC: begin
          if (dac_ack) begin
            dac_req  <= 1'b0;
            adc_req  <= 1'b1;
            adc_chan <= 1'b0;
            state_q  <= ST_ADC1;
          end
        end
        ST_ADC1: begin
          if (adc_ack) begin
            samp1_q  <= adc_data;
            adc_chan <= 1'b1;
            state_q  <= ST_ADC2;
          end
        end
        ST_ADC2: begin
          if (adc_ack) begin
            adc_req   <= 1'b0;
            acq_we    <= 1'b1;
            acq_waddr <= idx_q - st_start_q;
            acq_wdata <= {adc_data, samp1_q};
            state_q   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tmr_expired) begin
            if (last_step) begin
              busy    <= 1'b0;
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_FETCH;
              if (!pass_end) begin
                idx_q <= idx_q + 1'b1;
              end else begin
                idx_q <= st_start_q;
                if (cyc_end) begin
                  cyc_q <= '0;
                  rep_q <= rep_q + 1'b1;
                end else begin
                  cyc_q <= cyc_q + 1'b1;
                end
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top #(
  parameter int DEPTH    = 100,
  parameter int CODE_W   = 10,
  parameter int SAMP_W   = 10,
  parameter int DLY_W    = 8,
  parameter int CNT_W    = 8,
  parameter int STEP_CYC = 25000,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_waddr,
  input  logic [CODE_W-1:0] tbl_wdata,
  input  logic [IDX_W-1:0]  cfg_start,
  input  logic [IDX_W-1:0]  cfg_end,
  input  logic [DLY_W-1:0]  cfg_xdly,
  input  logic [CNT_W-1:0]  cfg_cycles,
  input  logic [CNT_W-1:0]  cfg_repeat,
  input  logic              run,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic              dac_req,
  output logic [CODE_W-1:0] dac_code,
  input  logic              dac_ack,
  output logic              adc_req,
  output logic              adc_chan,
  input  logic              adc_ack,
  input  logic [SAMP_W-1:0] adc_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic              rd_valid,
  output logic [SAMP_W-1:0] rd_data1,
  output logic [SAMP_W-1:0] rd_data2
);
  logic [IDX_W-1:0]    tbl_raddr;
  logic [DLY_W-1:0]    act_xdly;
  logic                step_go, tmr_expired;
  logic                acq_we;
  logic [IDX_W-1:0]    acq_waddr;
  logic [2*SAMP_W-1:0] acq_wdata, acq_rdata;

  burst_sdp_ram #(.DEPTH(DEPTH), .AW(IDX_W), .DW(CODE_W)) code_ram_i (
    .clk   (clk),
    .we    (tbl_we && !busy),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (tbl_raddr),
    .rdata (dac_code)
  );

  burst_sdp_ram #(.DEPTH(DEPTH), .AW(IDX_W), .DW(2*SAMP_W)) acq_ram_i (
    .clk   (clk),
    .we    (acq_we),
    .waddr (acq_waddr),
    .wdata (acq_wdata),
    .raddr (rd_addr),
    .rdata (acq_rdata)
  );

  burst_step_timer #(.STEP_CYC(STEP_CYC), .DLY_W(DLY_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (step_go),
    .enable  (busy),
    .xdly    (act_xdly),
    .expired (tmr_expired)
  );

  burst_seq_ctrl #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .SAMP_W(SAMP_W), .DLY_W(DLY_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .cfg_start   (cfg_start),
    .cfg_end     (cfg_end),
    .cfg_xdly    (cfg_xdly),
    .cfg_cycles  (cfg_cycles),
    .cfg_repeat  (cfg_repeat),
    .tmr_expired (tmr_expired),
    .dac_ack     (dac_ack),
    .adc_ack     (adc_ack),
    .adc_data    (adc_data),
    .busy        (busy),
    .done        (done),
    .cfg_err     (cfg_err),
    .dac_req     (dac_req),
    .adc_req     (adc_req),
    .adc_chan    (adc_chan),
    .tbl_raddr   (tbl_raddr),
    .act_xdly    (act_xdly),
    .step_go     (step_go),
    .acq_we      (acq_we),
    .acq_waddr   (acq_waddr),
    .acq_wdata   (acq_wdata)
  );

  // reads are served only from an idle block that is not being started
  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en && !busy && !run;
  end

  assign rd_data1 = acq_rdata[SAMP_W-1:0];
  assign rd_data2 = acq_rdata[2*SAMP_W-1:SAMP_W];
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic cfg_err,
  input logic dac_req,
  input logic dac_ack,
  input logic adc_req,
  input logic adc_ack,
  input logic adc_chan,
  input logic rd_valid
);
  p_done_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_req_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(dac_req && adc_req));
  p_dac_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (dac_req && !dac_ack) |=> dac_req);
  p_adc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (adc_req && !adc_ack) |=> (adc_req && $stable(adc_chan)));
  p_req_in_run_r3: assert property (@(posedge clk) disable iff (rst)
    (dac_req || adc_req) |-> busy);
  p_no_read_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rd_valid);
  p_err_no_run_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);
endmodule

bind burst_seq_top burst_seq_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .cfg_err  (cfg_err),
  .dac_req  (dac_req),
  .dac_ack  (dac_ack),
  .adc_req  (adc_req),
  .adc_ack  (adc_ack),
  .adc_chan (adc_chan),
  .rd_valid (rd_valid)
);

// File: tb/burst_seq_top_tb_top.sv
module burst_seq_top_tb_top;
  localparam int DEPTH = 100, CODE_W = 10, SAMP_W = 10, DLY_W = 4, CNT_W = 4;
  localparam int STEP = 12, IDX_W = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic tbl_we = 0; logic [IDX_W-1:0] tbl_waddr = '0; logic [CODE_W-1:0] tbl_wdata = '0;
  logic [IDX_W-1:0] cfg_start = '0, cfg_end = '0;
  logic [DLY_W-1:0] cfg_xdly = '0;
  logic [CNT_W-1:0] cfg_cycles = '0, cfg_repeat = '0;
  logic run = 0, busy, done, cfg_err, dac_req, dac_ack = 0, adc_req, adc_chan, adc_ack = 0;
  logic [CODE_W-1:0] dac_code;
  logic [SAMP_W-1:0] adc_data = '0;
  logic rd_en = 0; logic [IDX_W-1:0] rd_addr = '0;
  logic rd_valid; logic [SAMP_W-1:0] rd_data1, rd_data2;

  int checks = 0, failures = 0, cyc = 0, samp_n = 0, chan_err = 0, log_n = 0;
  int log_code [2048];
  int log_cyc  [2048];
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc++;

  burst_seq_top #(.DEPTH(DEPTH), .CODE_W(CODE_W), .SAMP_W(SAMP_W), .DLY_W(DLY_W),
                  .CNT_W(CNT_W), .STEP_CYC(STEP)) dut_i (.*);

  function automatic int tcode(int i); return (i * 29 + 3) % 1024; endfunction
  function automatic int sval(int n);  return (n * 37 + 5) % 1024; endfunction

  // DAC and ADC responders, acting at the falling edge
  always @(negedge clk) begin
    if (dac_req && !dac_ack) begin
      dac_ack = 1'b1;
      if (log_n < 2048) begin log_code[log_n] = int'(dac_code); log_cyc[log_n] = cyc; end
      log_n++;
    end else dac_ack = 1'b0;
    if (adc_req && !adc_ack) begin
      adc_ack = 1'b1;
      if (adc_chan != samp_n[0]) chan_err++;
      adc_data = SAMP_W'(sval(samp_n));
      samp_n++;
    end else adc_ack = 1'b0;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_run(int s, int e, int x, int c, int r, bit disturb);
    int span = e - s + 1;
    int passes = c * r;
    int per = STEP * (x + 1);
    int nsteps = span * passes;
    int n0 = samp_n;
    int bcnt = 0;
    int ce0 = chan_err;
    log_n = 0;
    @(negedge clk);
    cfg_start = IDX_W'(s); cfg_end = IDX_W'(e); cfg_xdly = DLY_W'(x);
    cfg_cycles = CNT_W'(c); cfg_repeat = CNT_W'(r); run = 1;
    @(negedge clk);
    run = 0;
    chk(busy == 1, "R3", "busy after run", int'(busy), 1);
    while (busy && bcnt < 20000) begin
      bcnt++;
      if (disturb && bcnt == 20) begin
        tbl_we = 1; tbl_waddr = 5; tbl_wdata = 0;
        run = 1; cfg_cycles = 1; cfg_repeat = 1; cfg_end = cfg_start;
        rd_en = 1; rd_addr = 0;
      end
      if (disturb && bcnt == 21) begin
        tbl_waddr = 22;
        run = 0; rd_en = 0;
        chk(rd_valid == 0, "R5", "read served while busy", int'(rd_valid), 0);
      end
      if (disturb && bcnt == 22) tbl_we = 0;
      @(negedge clk);
    end
    chk(bcnt == nsteps * per, "R3", "busy length", bcnt, nsteps * per);
    chk(done == 1, "R10", "done at busy fall", int'(done), 1);
    @(negedge clk);
    chk(done == 0, "R10", "done width", int'(done), 0);
    chk(log_n == nsteps, "R4", "step count", log_n, nsteps);
    for (int k = 0; k < log_n && k < 2048; k++) begin
      if (log_code[k] != tcode(s + k % span))
        chk(0, "R1", "played code", log_code[k], tcode(s + k % span));
      if (k > 0 && log_cyc[k] - log_cyc[k-1] != per)
        chk(0, "R3", "step spacing", log_cyc[k] - log_cyc[k-1], per);
    end
    chk(1, "R1", "code sequence scanned", 0, 0);
    chk(chan_err == ce0, "R2", "adc channel order", chan_err - ce0, 0);
    for (int j = 0; j < span; j++) begin
      int nb = n0 + 2 * ((passes - 1) * span + j);
      @(negedge clk);
      rd_en = 1; rd_addr = IDX_W'(j);
      @(negedge clk);
      rd_en = 0;
      chk(rd_valid == 1, "R7", "rd_valid", int'(rd_valid), 1);
      chk(int'(rd_data1) == sval(nb), "R8", "input1 sample", int'(rd_data1), sval(nb));
      chk(int'(rd_data2) == sval(nb + 1), "R8", "input2 sample", int'(rd_data2), sval(nb + 1));
    end
  endtask

  task automatic bad_run(int s, int e, int c, int r, string what);
    @(negedge clk);
    cfg_start = IDX_W'(s); cfg_end = IDX_W'(e); cfg_xdly = 0;
    cfg_cycles = CNT_W'(c); cfg_repeat = CNT_W'(r); run = 1;
    @(negedge clk);
    run = 0;
    chk(cfg_err == 1, "R9", what, int'(cfg_err), 1);
    repeat (4) @(negedge clk);
    chk(busy == 0 && dac_req == 0, "R9", {what, " no start"}, int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({busy, done, cfg_err, dac_req, adc_req, rd_valid} == 6'b0, "R11", "reset outputs",
        int'({busy, done, cfg_err, dac_req, adc_req, rd_valid}), 0);
    for (int i = 0; i < DEPTH; i++) begin
      tbl_we = 1; tbl_waddr = IDX_W'(i); tbl_wdata = CODE_W'(tcode(i));
      @(negedge clk);
    end
    tbl_we = 0;
    do_run(3, 10, 0, 1, 1, 0);          // R1 R2 R3 basic list
    chk(cfg_err == 0, "R9", "no error on valid run", int'(cfg_err), 0);
    do_run(20, 24, 2, 2, 3, 1);         // R4 R8 passes, R5 disturbances
    do_run(0, 99, 0, 1, 1, 0);          // full span, R5 write to 22 ignored
    bad_run(0, 5, 0, 1, "zero cycles");
    bad_run(0, 5, 1, 0, "zero repeat");
    bad_run(9, 8, 1, 1, "end below start");
    bad_run(0, 100, 1, 1, "span above depth");
    do_run(3, 10, 0, 1, 1, 0);          // R6 rerun, R5 write to 5 ignored
    chk(cfg_err == 0, "R9", "error cleared by accepted run", int'(cfg_err), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule